// File: doc/BRIEF.md
# Fractional-N Serial Bit-Rate Generator

This block produces the timing strobes for a serial port. It divides a selected clock source by a 16-bit integer divisor. In asynchronous normal mode it adds a fractional part, in eighths, by lengthening some division periods by one source cycle. The generator yields two strobes:

- a sampling strobe at 8x or 16x the bit rate;
- a bit-rate strobe.

In synchronous mode the source is divided by the integer divisor alone, and both strobes fire together. In synchronous mode with the external clock selected, each rising edge of the external serial clock gives one pair of strobes, with no division.

Every output is a single-cycle enable in the peripheral clock domain. The external serial clock arrives already synchronised. Any change to the configuration restarts every counter from a clean reload, so no partial period is ever emitted.

Top module: `frac_baud_gen`

## Requirements
- R1: `clk_sel` picks the source pulses that feed the divider. 0 gives one pulse per clock. 1 gives one pulse every DIV clocks, the first of them DIV clocks after a restart. 2 is reserved and gives no pulses. 3 gives one pulse per rising edge of `ext_sclk` (high now, low the cycle before).
- R2: In asynchronous mode with an effective fraction of 0, a sampling strobe ends every `div_int` source pulses. `over8` selects the bit-rate strobe: 0 gives one on every 16th sampling strobe, 1 gives one on every 8th.
- R3: With a nonzero effective fraction F, a 3-bit accumulator starts at 0 and adds F at the end of each sampling period. The carry out of that addition makes the next period `div_int`+1 source pulses long. So exactly F of every 8 consecutive periods are long, and the first period after a restart is `div_int` long.
- R4: A bit-rate strobe only ever occurs in the same cycle as a sampling strobe.
- R5: The fraction takes effect only when `sync_mode`=0 and `normal_mode`=1. In every other case `div_frac` is treated as zero.
- R6: The period modulus (`div_int` or `div_int`+1) changes only at the end of a sampling period.
- R7: With `sync_mode`=1 and `clk_sel` 0 or 1, both strobes fire together every `div_int` source pulses. No oversampling divider is applied.
- R8: With `sync_mode`=1 and `clk_sel`=3, every rising edge of `ext_sclk` gives both strobes, and `div_int` is ignored (0 included).
- R9: `active` is low, and no strobe is produced, when `clk_sel`=2, or when `div_int`=0 outside the case in R8. Otherwise `active` is high.
- R10: If any configuration input differs from its value in the previous cycle, the strobes are low in the following cycle. All counters, the prescaler and the accumulator then restart from zero.
- R11: Strobes are registered. A strobe is high in the cycle after the cycle in which the completing source pulse was present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 2 | Source select: 0 clock, 1 clock/DIV, 2 reserved, 3 external |
| div_int | input | 16 | Integer divisor |
| div_frac | input | 3 | Fraction in eighths |
| over8 | input | 1 | 1: 8x oversampling, 0: 16x |
| sync_mode | input | 1 | 1: synchronous mode |
| normal_mode | input | 1 | 1: normal mode, which permits the fraction |
| ext_sclk | input | 1 | Synchronised external serial clock level |
| sample_tick | output | 1 | Oversampling strobe |
| baud_tick | output | 1 | Bit-rate strobe |
| active | output | 1 | Generator is producing strobes |

## Verification
Each strobe is due one clock after the cycle in which its completing source pulse is present. A configuration change silences the strobes for exactly the next cycle. `active` follows the inputs combinationally within the same cycle. The bench changes inputs shortly after the rising edge. A behavioural model advances on that same edge, and the outputs are compared at the falling edge, so both the registered strobes and the combinational flag are sampled where their values have settled.

// File: rtl/frac_baud_pkg.sv
// Shared widths and the configuration record of the bit-rate generator.
package frac_baud_pkg;
    parameter int unsigned BG_CD_W = 16;  // integer divisor width
    parameter int unsigned BG_FP_W = 3;   // fraction width (eighths)

    typedef enum logic [1:0] {
        SRC_PCLK = 2'd0,
        SRC_PDIV = 2'd1,
        SRC_RSVD = 2'd2,
        SRC_EXT  = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic [1:0]         clk_sel;
        logic [BG_CD_W-1:0] cd;
        logic [BG_FP_W-1:0] fp;
        logic               over8;
        logic               sync_mode;
        logic               normal_mode;
    } bg_cfg_t;
endpackage

// File: rtl/bg_src_sel.sv
// Source pulse selector: turns the clock-select field into a one-cycle
// enable per source cycle. Assumes ext_sclk is already synchronised.
module bg_src_sel #(
    parameter int unsigned DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] clk_sel,
    input  logic       ext_sclk,
    output logic       src_en
);
    import frac_baud_pkg::*;
    localparam int unsigned PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic             ext_q;
    logic             pre_tick;
    logic             ext_rise;

    assign pre_tick = (pre_q == PRE_LAST);
    assign ext_rise = ext_sclk && !ext_q;

    // Fixed prescaler, cleared on every restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)   pre_q <= '0;
        else if (pre_tick)       pre_q <= '0;
        else                     pre_q <= pre_q + 1'b1;
    end

    // Previous external level for edge detection; never cleared by restart.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_sclk;
    end

    // Source enable multiplexer.
    always_comb begin
        unique case (src_sel_e'(clk_sel))
            SRC_PCLK: src_en = 1'b1;
            SRC_PDIV: src_en = pre_tick;
            SRC_EXT:  src_en = ext_rise;
            default:  src_en = 1'b0;
        endcase
    end

    a_r1_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);
endmodule

// File: rtl/bg_frac_div.sv
// Modulus-controlled divider: counts source pulses up to CD or CD+1.
// A 3-bit phase accumulator supplies the modulus-control carry, which
// is latched only at a period end. Assumes fp_eff is zero when the
// fraction is not permitted.
module bg_frac_div #(
    parameter int unsigned CD_W = 16,
    parameter int unsigned FP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            src_en,
    input  logic [CD_W-1:0] cd,
    input  logic [FP_W-1:0] fp_eff,
    output logic            per_end
);
    logic [CD_W-1:0] cnt_q;
    logic [FP_W-1:0] acc_q;
    logic            long_q;
    logic [FP_W:0]   acc_sum;
    logic [CD_W-1:0] lim;

    assign lim     = cd - CD_W'(1) + CD_W'(long_q);
    assign per_end = src_en && (cd != '0) && (cnt_q == lim);
    assign acc_sum = {1'b0, acc_q} + {1'b0, fp_eff};

    // Period counter: reload at the end, step on each source pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)            cnt_q <= '0;
        else if (per_end)                 cnt_q <= '0;
        else if (src_en && cd != '0)      cnt_q <= cnt_q + 1'b1;
    end

    // Phase accumulator; its carry selects the next period's modulus.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc_q  <= '0;
            long_q <= 1'b0;
        end else if (per_end) begin
            acc_q  <= acc_sum[FP_W-1:0];
            long_q <= acc_sum[FP_W];
        end
    end

    // R6: modulus control changes only at a period end.
    a_r6_mod_at_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !per_end) |=> $stable(long_q));
    // R3: the count never passes the current period length.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cd != '0 && !restart) |-> ({1'b0, cnt_q} <= {1'b0, cd} - 1 + long_q));
endmodule

// File: rtl/bg_ovs_div.sv
// Oversampling divider: counts sampling periods into bit periods
// (16 or 8); in synchronous mode every period is a bit period.
module bg_ovs_div #(
    parameter int unsigned OVS_MAX = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic per_end,
    input  logic over8,
    input  logic sync_mode,
    output logic bit_end
);
    localparam int unsigned GRP_W = $clog2(OVS_MAX);
    localparam logic [GRP_W-1:0] LAST16 = GRP_W'(OVS_MAX - 1);
    localparam logic [GRP_W-1:0] LAST8  = GRP_W'(OVS_MAX / 2 - 1);

    logic [GRP_W-1:0] grp_q;
    logic [GRP_W-1:0] last;

    assign last    = over8 ? LAST8 : LAST16;
    assign bit_end = per_end && (sync_mode || grp_q == last);

    // Group counter over sampling periods.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)          grp_q <= '0;
        else if (per_end && !sync_mode) grp_q <= (grp_q == last) ? '0 : grp_q + 1'b1;
    end

    a_r2_group_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> grp_q <= last);
endmodule

// File: rtl/frac_baud_gen.sv
// Fractional-N serial bit-rate generator top. Detects configuration
// changes, selects the bypass path for the external synchronous clock
// and registers both strobes. Assumes all inputs are in the clk domain.
module frac_baud_gen #(
    parameter int unsigned DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  clk_sel,
    input  logic [15:0] div_int,
    input  logic [2:0]  div_frac,
    input  logic        over8,
    input  logic        sync_mode,
    input  logic        normal_mode,
    input  logic        ext_sclk,
    output logic        sample_tick,
    output logic        baud_tick,
    output logic        active
);
    import frac_baud_pkg::*;

    bg_cfg_t cfg, cfg_q;
    logic    restart, src_en, per_end, bit_end, bypass, frac_ok;
    logic [BG_FP_W-1:0] fp_eff;

    assign cfg     = '{clk_sel: clk_sel, cd: div_int, fp: div_frac,
                       over8: over8, sync_mode: sync_mode, normal_mode: normal_mode};
    assign restart = (cfg != cfg_q);
    assign bypass  = sync_mode && (clk_sel == 2'(SRC_EXT));
    assign frac_ok = normal_mode && !sync_mode;
    assign fp_eff  = frac_ok ? div_frac : '0;
    assign active  = bypass || (div_int != '0 && clk_sel != 2'(SRC_RSVD));

    // Remember the configuration to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg;
    end

    bg_src_sel #(.DIV(DIV)) u_src (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .clk_sel(clk_sel), .ext_sclk(ext_sclk), .src_en(src_en));

    bg_frac_div #(.CD_W(BG_CD_W), .FP_W(BG_FP_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(restart), .src_en(src_en),
        .cd(div_int), .fp_eff(fp_eff), .per_end(per_end));

    bg_ovs_div #(.OVS_MAX(16)) u_ovs (
        .clk(clk), .rst_n(rst_n), .restart(restart), .per_end(per_end),
        .over8(over8), .sync_mode(sync_mode), .bit_end(bit_end));

    // Output strobe registers, silenced on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sample_tick <= 1'b0;
            baud_tick   <= 1'b0;
        end else begin
            sample_tick <= bypass ? src_en : per_end;
            baud_tick   <= bypass ? src_en : bit_end;
        end
    end

    a_r4_baud_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> sample_tick);
    a_r9_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !sample_tick && !baud_tick);
    a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sample_tick && !baud_tick);
endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
    localparam int DIV = 8;

    logic clk = 0, rst_n = 0;
    logic [1:0] clk_sel = 0;
    logic [15:0] div_int = 0;
    logic [2:0] div_frac = 0;
    logic over8 = 0, sync_mode = 0, normal_mode = 1, ext_sclk = 0;
    logic sample_tick, baud_tick, active;

    int tests = 0, fails = 0, cycles = 0;
    bit ext_run = 0, chk_on = 0;
    string cur_req = "R11";
    int win_ticks = 0;

    // model state
    int m_pre, m_cnt, m_acc, m_long, m_grp;
    bit m_extp, exp_s, exp_b;
    logic [25:0] m_cfgp;

    frac_baud_gen #(.DIV(DIV)) u_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .div_int(div_int),
        .div_frac(div_frac), .over8(over8), .sync_mode(sync_mode),
        .normal_mode(normal_mode), .ext_sclk(ext_sclk),
        .sample_tick(sample_tick), .baud_tick(baud_tick), .active(active));

    always #4 clk = ~clk;

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        logic [25:0] cfgv;
        bit src;
        int fpe;
        cfgv = {clk_sel, div_int, div_frac, over8, sync_mode, normal_mode};
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_acc = 0; m_long = 0; m_grp = 0;
            m_extp = 0; exp_s = 0; exp_b = 0; m_cfgp = '0;
        end else begin
            case (clk_sel)
                2'd0: src = 1;
                2'd1: src = (m_pre == DIV - 1);
                2'd3: src = ext_sclk && !m_extp;
                default: src = 0;
            endcase
            m_extp = ext_sclk;
            exp_s = 0; exp_b = 0;
            if (cfgv != m_cfgp) begin
                m_cfgp = cfgv; m_pre = 0; m_cnt = 0; m_acc = 0; m_long = 0; m_grp = 0;
            end else begin
                m_pre = (m_pre + 1) % DIV;
                if (sync_mode && clk_sel == 2'd3) begin
                    exp_s = src; exp_b = src;
                end else if (div_int != 0 && src) begin
                    m_cnt++;
                    if (m_cnt == int'(div_int) + m_long) begin
                        m_cnt = 0; exp_s = 1;
                        if (sync_mode) exp_b = 1;
                        else begin
                            fpe = normal_mode ? int'(div_frac) : 0;
                            m_acc += fpe;
                            m_long = (m_acc >= 8) ? 1 : 0;
                            m_acc %= 8;
                            m_grp++;
                            if (m_grp == (over8 ? 8 : 16)) begin m_grp = 0; exp_b = 1; end
                        end
                    end
                end
            end
        end
    end

    // Compare on the falling edge, away from register updates.
    always @(negedge clk) begin
        bit exp_a;
        cycles++;
        if (sample_tick) win_ticks++;
        if (chk_on) begin
            exp_a = (sync_mode && clk_sel == 2'd3) || (div_int != 0 && clk_sel != 2'd2);
            tests++;
            if (sample_tick !== exp_s || baud_tick !== exp_b || active !== exp_a) begin
                fails++;
                $display("FAIL %s: got s=%b b=%b a=%b exp s=%b b=%b a=%b at cycle %0d",
                         cur_req, sample_tick, baud_tick, active, exp_s, exp_b, exp_a, cycles);
            end
        end
    end

    // External serial clock: toggles every other cycle when enabled.
    always @(posedge clk) begin
        if (ext_run && (cycles % 2 == 0)) #1 ext_sclk = ~ext_sclk;
    end

    task automatic run(input string req, input logic [1:0] sel, input int cd, input int fp,
                       input bit ov, input bit sy, input bit nm, input int n);
        @(posedge clk); #1;
        cur_req = req; clk_sel = sel; div_int = 16'(cd); div_frac = 3'(fp);
        over8 = ov; sync_mode = sy; normal_mode = nm;
        repeat (n) @(posedge clk);
    endtask

    task automatic count_check(input string req, input int lo, input int hi);
        tests++;
        if (win_ticks < lo || win_ticks > hi) begin
            fails++;
            $display("FAIL %s: tick count %0d expected %0d..%0d", req, win_ticks, lo, hi);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        tests++;  // R11 reset state
        if (sample_tick !== 0 || baud_tick !== 0) begin
            fails++; $display("FAIL R11: reset strobes s=%b b=%b expected 0 0", sample_tick, baud_tick);
        end
        rst_n = 1; chk_on = 1;
        run("R2", 2'd0, 4, 0, 0, 0, 1, 200);
        run("R2", 2'd0, 3, 0, 1, 0, 1, 120);
        run("R3", 2'd0, 4, 3, 0, 0, 1, 400);
        run("R3", 2'd0, 2, 7, 1, 0, 1, 200);
        run("R3", 2'd0, 1, 1, 1, 0, 1, 100);
        // R3 average ratio: cd=4 fp=3 gives 35 cycles per 8 periods
        run("R3", 2'd0, 4, 3, 0, 0, 1, 2);
        win_ticks = 0;
        repeat (280) @(posedge clk);
        count_check("R3", 63, 65);
        run("R5", 2'd0, 3, 5, 1, 0, 0, 150);
        run("R1", 2'd1, 2, 0, 1, 0, 1, 400);
        run("R1", 2'd2, 3, 0, 0, 0, 1, 60);
        run("R7", 2'd0, 5, 0, 0, 1, 1, 100);
        run("R5", 2'd1, 3, 6, 0, 1, 1, 200);
        ext_run = 1;
        run("R8", 2'd3, 0, 0, 0, 1, 1, 100);
        run("R8", 2'd3, 9, 4, 1, 1, 1, 100);
        run("R1", 2'd3, 2, 2, 1, 0, 1, 300);
        ext_run = 0;
        run("R9", 2'd0, 0, 3, 0, 0, 1, 60);
        // R10: mid-period changes restart cleanly
        run("R10", 2'd0, 5, 2, 1, 0, 1, 13);
        run("R10", 2'd0, 5, 3, 1, 0, 1, 7);
        run("R10", 2'd0, 6, 3, 1, 0, 1, 1);
        run("R10", 2'd0, 6, 3, 0, 0, 1, 150);
        run("R6", 2'd0, 2, 5, 1, 0, 1, 200);
        run("R4", 2'd0, 1, 0, 1, 0, 1, 50);
        chk_on = 0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule